// File: doc/BRIEF.md
# Timer Flag Block with Fast-Clear

The block holds a free-running 16-bit timer counter together with the event flags of a small timer: one flag per capture/compare channel, a counter-overflow flag and two pulse-accumulator flags (count overflow and input edge). Capture, compare, pin and pulse-counting datapaths live elsewhere. Their events arrive at this block as one-cycle set pulses, and the block only keeps the flags and decides when they clear. Software reaches it through a byte-wide slave port that has an address, a read strobe, a write strobe and write data. Read data is combinational from the address.

A control bit picks one of two clearing methods. In the normal method software writes a 1 to the flag bit. In the fast method a flag clears as a side effect of touching the data register it belongs to: reading an input-capture channel, writing an output-compare channel, accessing either counter byte, or accessing either pulse-accumulator count byte. A freeze input can stop the counter when a control bit allows it. It never blocks the pulse-accumulator flags.

Address map (5-bit address): 0x00 counter high byte, 0x01 counter low byte, 0x02 control (bit0 count enable, bit1 stop-in-freeze, bit2 fast-clear), 0x03 channel mode (bit n = 1 makes channel n output-compare, 0 makes it input-capture), 0x04 channel flags (bit n = channel n), 0x05 misc flags (bit0 counter overflow, bit1 accumulator overflow, bit2 accumulator edge), 0x06 / 0x07 accumulator count high / low, and 0x10+2n / 0x11+2n channel n data high / low. Unmapped addresses read 0.

Top module: `tmr_flagblk`

## Requirements
- R1: After reset the counter, the control register, the channel mode register and every flag read as 0.
- R2: With control bit0 = 1 and no freeze hold, the counter adds one per clock. With bit0 = 0 it holds. A write to address 0x00 or 0x01 loads that counter byte and takes priority over counting in that cycle.
- R3: When control bit1 = 1 and the freeze input is high, the counter holds. When bit1 = 0, the counter keeps counting while the freeze input is high.
- R4: When a counting step takes the counter from 0xFFFF to 0x0000, misc flag bit0 is set on that same clock edge.
- R5: A pulse on channel event n sets channel flag bit n, and a pulse on the accumulator overflow or edge input sets misc bit1 or bit2, on the next clock edge. The accumulator flags set whatever the freeze input and control bit1 are.
- R6: With control bit2 = 0, writing to a flag register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: With control bit2 = 1, a read of either data byte of an input-capture channel clears that channel's flag. A write to such a channel does not clear it.
- R8: With control bit2 = 1, a write to either data byte of an output-compare channel clears that channel's flag. A read of such a channel does not clear it.
- R9: With control bit2 = 1, a read or a write of address 0x00 or 0x01 clears misc bit0.
- R10: With control bit2 = 1, a read or a write of address 0x06 or 0x07 clears both misc bit1 and bit2.
- R11: Fast clearing and write-one clearing never mix. With bit2 = 1, writes to the flag registers clear nothing. With bit2 = 0, data register accesses clear nothing.
- R12: If a flag's set event and its clear condition occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register address |
| bus_rd | input | 1 | Read strobe (side effects take place on the clock edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| frz_in | input | 1 | Freeze-mode indication |
| chan_evt | input | 8 | Per-channel flag set pulses |
| pa_ovf_evt | input | 1 | Accumulator overflow set pulse |
| pa_edge_evt | input | 1 | Accumulator edge set pulse |
| cnt_out | output | 16 | Current counter value |

## Verification
The bench drives each channel through its wrong-direction access: a write to a capture channel and a read of a compare channel must both leave the flag set. A design that decodes the mode backwards, or ignores it, clears the wrong flag. Writing zeros to the flag register in normal mode, and writing ones to it in fast mode, catches designs that clear on any flag write or that leave write-one clearing active in fast mode. A clear and a set are landed in the same cycle, which exposes a clear-wins priority. The counter is loaded to 0xFFFF and stepped once, which checks the wrap into the overflow flag. Freeze is tried with the stop bit both set and cleared: a design that gates on the freeze input alone, or that lets freeze block the accumulator flags, shows a wrong count or a missing flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 16;

    localparam logic [ADDR_W-1:0] A_CNT_HI = 5'h00;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 5'h01;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h02;
    localparam logic [ADDR_W-1:0] A_CHMODE = 5'h03;
    localparam logic [ADDR_W-1:0] A_CHFLG  = 5'h04;
    localparam logic [ADDR_W-1:0] A_MFLG   = 5'h05;
    localparam logic [ADDR_W-1:0] A_PA_HI  = 5'h06;
    localparam logic [ADDR_W-1:0] A_PA_LO  = 5'h07;

    typedef struct packed {
        logic fast_clr;
        logic frz_stop;
        logic cnt_en;
    } ctrl_t;

    typedef struct packed {
        logic pa_edge;
        logic pa_ovf;
        logic cnt_ovf;
    } mflg_t;

    // Channel data window: bit 4 set, bits 3:1 pick the channel.
    function automatic logic is_chan(input logic [ADDR_W-1:0] a, input int n);
        return a[4] && (int'(a[3:1]) == n);
    endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld_hi,
    input  logic             ld_lo,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (ld_hi || ld_lo) begin
            if (ld_hi) st_d.cnt[15:8] = wdata;
            if (ld_lo) st_d.cnt[7:0]  = wdata;
        end else if (run) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = (st_q.cnt == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output ctrl_t                  ctrl,
    output logic [NCH-1:0]         chmode,
    output logic [15:0]            pacnt,
    output logic [NCH-1:0][15:0]   chdat
);
    typedef struct packed {
        ctrl_t                 ctrl;
        logic [NCH-1:0]        chmode;
        logic [15:0]           pacnt;
        logic [NCH-1:0][15:0]  chdat;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (addr == A_CTRL)   st_d.ctrl   = ctrl_t'(wdata[2:0]);
            if (addr == A_CHMODE) st_d.chmode = wdata[NCH-1:0];
            if (addr == A_PA_HI)  st_d.pacnt[15:8] = wdata;
            if (addr == A_PA_LO)  st_d.pacnt[7:0]  = wdata;
            for (int n = 0; n < NCH; n++) begin
                if (is_chan(addr, n)) begin
                    if (addr[0]) st_d.chdat[n][7:0]  = wdata;
                    else         st_d.chdat[n][15:8] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl   = st_q.ctrl;
    assign chmode = st_q.chmode;
    assign pacnt  = st_q.pacnt;
    assign chdat  = st_q.chdat;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [NCH-1:0]    chmode,
    input  logic [NCH-1:0]    chan_evt,
    input  logic              ovf_evt,
    input  logic              pa_ovf_evt,
    input  logic              pa_edge_evt,
    output logic [NCH-1:0]    ch_flg,
    output mflg_t             mflg
);
    typedef struct packed {
        logic [NCH-1:0] ch;
        mflg_t          m;
    } flg_st_t;

    flg_st_t        st_d, st_q;
    logic [NCH-1:0] ch_clr;
    mflg_t          m_clr;
    logic           acc;

    always_comb begin
        acc    = rd || wr;
        ch_clr = '0;
        m_clr  = '0;
        if (fast) begin
            for (int n = 0; n < NCH; n++) begin
                if (is_chan(addr, n))
                    ch_clr[n] = chmode[n] ? wr : rd;
            end
            if (acc && (addr == A_CNT_HI || addr == A_CNT_LO))
                m_clr.cnt_ovf = 1'b1;
            if (acc && (addr == A_PA_HI || addr == A_PA_LO)) begin
                m_clr.pa_ovf  = 1'b1;
                m_clr.pa_edge = 1'b1;
            end
        end else if (wr) begin
            if (addr == A_CHFLG) ch_clr = wdata[NCH-1:0];
            if (addr == A_MFLG)  m_clr  = mflg_t'(wdata[2:0]);
        end

        st_d.ch        = (st_q.ch & ~ch_clr) | chan_evt;
        st_d.m.cnt_ovf = (st_q.m.cnt_ovf & ~m_clr.cnt_ovf) | ovf_evt;
        st_d.m.pa_ovf  = (st_q.m.pa_ovf  & ~m_clr.pa_ovf)  | pa_ovf_evt;
        st_d.m.pa_edge = (st_q.m.pa_edge & ~m_clr.pa_edge) | pa_edge_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_flg = st_q.ch;
    assign mflg   = st_q.m;

    // R5 R12
    ch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_evt != '0) |=> ((ch_flg & $past(chan_evt)) == $past(chan_evt)));

    // R6
    zero_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast && wr && addr == A_CHFLG)
        |=> ((~$past(ch_flg) | ch_flg | $past(wdata[NCH-1:0])) == '1));

    // R11
    fast_flgwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && wr && addr == A_CHFLG) |=> ((~$past(ch_flg) | ch_flg) == '1));

    // R10
    pa_fastclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && (rd || wr) && (addr == A_PA_HI || addr == A_PA_LO)
         && !pa_ovf_evt && !pa_edge_evt) |=> (!mflg.pa_ovf && !mflg.pa_edge));
endmodule

// File: rtl/tmr_flagblk.sv
module tmr_flagblk
    import tmr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              frz_in,
    input  logic [NCH-1:0]    chan_evt,
    input  logic              pa_ovf_evt,
    input  logic              pa_edge_evt,
    output logic [CNT_W-1:0]  cnt_out
);
    ctrl_t                ctrl;
    logic [NCH-1:0]       chmode;
    logic [15:0]          pacnt;
    logic [NCH-1:0][15:0] chdat;
    logic [NCH-1:0]       ch_flg;
    mflg_t                mflg;
    logic                 run, wrap, ld_hi, ld_lo;
    logic [CNT_W-1:0]     cnt_q;

    assign run   = ctrl.cnt_en && !(ctrl.frz_stop && frz_in);
    assign ld_hi = bus_wr && (bus_addr == A_CNT_HI);
    assign ld_lo = bus_wr && (bus_addr == A_CNT_LO);

    tmr_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ld_hi (ld_hi),
        .ld_lo (ld_lo),
        .wdata (bus_wdata),
        .cnt_q (cnt_q),
        .wrap  (wrap)
    );

    tmr_regs #(.NCH(NCH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .ctrl   (ctrl),
        .chmode (chmode),
        .pacnt  (pacnt),
        .chdat  (chdat)
    );

    tmr_flags #(.NCH(NCH)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .fast        (ctrl.fast_clr),
        .rd          (bus_rd),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .chmode      (chmode),
        .chan_evt    (chan_evt),
        .ovf_evt     (wrap),
        .pa_ovf_evt  (pa_ovf_evt),
        .pa_edge_evt (pa_edge_evt),
        .ch_flg      (ch_flg),
        .mflg        (mflg)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_HI: bus_rdata = cnt_q[15:8];
            A_CNT_LO: bus_rdata = cnt_q[7:0];
            A_CTRL:   bus_rdata = {5'b0, ctrl};
            A_CHMODE: bus_rdata[NCH-1:0] = chmode;
            A_CHFLG:  bus_rdata[NCH-1:0] = ch_flg;
            A_MFLG:   bus_rdata = {5'b0, mflg};
            A_PA_HI:  bus_rdata = pacnt[15:8];
            A_PA_LO:  bus_rdata = pacnt[7:0];
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (is_chan(bus_addr, n))
                        bus_rdata = bus_addr[0] ? chdat[n][7:0] : chdat[n][15:8];
                end
            end
        endcase
    end

    assign cnt_out = cnt_q;

    // R3
    cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.frz_stop && frz_in && !ld_hi && !ld_lo) |=> $stable(cnt_out));

    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_out == 16'hFFFF && ctrl.cnt_en && !frz_in && !ld_hi && !ld_lo)
        |=> (cnt_out == 16'h0000 && mflg.cnt_ovf));
endmodule

// File: tb/tmr_flagblk_bench.sv
module tmr_flagblk_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frz_in = 1'b0;
    logic [7:0] chan_evt = '0;
    logic       pa_ovf_evt = 1'b0, pa_edge_evt = 1'b0;
    logic [15:0] cnt_out;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    tmr_flagblk u_tmr_flagblk (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frz_in(frz_in), .chan_evt(chan_evt), .pa_ovf_evt(pa_ovf_evt),
        .pa_edge_evt(pa_edge_evt), .cnt_out(cnt_out)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic load_cnt(input logic [15:0] v);
        wr(5'h00, v[15:8]);
        wr(5'h01, v[7:0]);
    endtask

    // counts k+1 steps when enabled
    task automatic run_ctrl(input logic [7:0] c, input int k);
        wr(5'h02, c);
        repeat (k) @(negedge clk);
        wr(5'h02, 8'h00);
    endtask

    task automatic pulse(input logic [7:0] ch, input logic po, input logic pe);
        chan_evt = ch; pa_ovf_evt = po; pa_edge_evt = pe;
        @(negedge clk);
        chan_evt = '0; pa_ovf_evt = 1'b0; pa_edge_evt = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        peek(5'h02, d); check("R1 ctrl", d, 8'h00);
        peek(5'h03, d); check("R1 chmode", d, 8'h00);
        peek(5'h04, d); check("R1 chflg", d, 8'h00);
        peek(5'h05, d); check("R1 mflg", d, 8'h00);
        check("R1 cnt", cnt_out, 16'h0000);
    endtask

    task automatic t_count;
        load_cnt(16'h1234);
        repeat (3) @(negedge clk);
        check("R2 load/hold", cnt_out, 16'h1234);
        run_ctrl(8'h01, 9);
        check("R2 count", cnt_out, 16'h123E);
    endtask

    task automatic t_freeze;
        logic [7:0] d;
        frz_in = 1'b1;
        load_cnt(16'h0100);
        run_ctrl(8'h03, 9);
        check("R3 frozen hold", cnt_out, 16'h0100);
        run_ctrl(8'h01, 9);
        check("R3 run in freeze", cnt_out, 16'h010A);
        wr(5'h02, 8'h03);
        pulse(8'h00, 1'b1, 1'b1);
        peek(5'h05, d); check("R5 pa flags in freeze", d, 8'h06);
        wr(5'h02, 8'h00);
        wr(5'h05, 8'h06);
        frz_in = 1'b0;
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        load_cnt(16'hFFFF);
        run_ctrl(8'h01, 0);
        check("R4 wrap value", cnt_out, 16'h0000);
        peek(5'h05, d); check("R4 ovf set", d, 8'h01);
        wr(5'h05, 8'h01);
    endtask

    task automatic t_normal;
        logic [7:0] d;
        pulse(8'hA5, 1'b0, 1'b0);
        peek(5'h04, d); check("R5 set", d, 8'hA5);
        wr(5'h04, 8'h05);
        peek(5'h04, d); check("R6 clear ones", d, 8'hA0);
        wr(5'h04, 8'h00);
        peek(5'h04, d); check("R6 zeros keep", d, 8'hA0);
        wr(5'h04, 8'hA0);
        wr(5'h03, 8'hF0);
        pulse(8'hFF, 1'b1, 1'b1);
        rd(5'h10, d); wr(5'h1A, 8'h55); rd(5'h06, d); rd(5'h00, d);
        peek(5'h04, d); check("R11 normal data access ch", d, 8'hFF);
        peek(5'h05, d); check("R11 normal data access misc", d, 8'h06);
        chan_evt = 8'h08;
        wr(5'h04, 8'hFF);
        chan_evt = 8'h00;
        peek(5'h04, d); check("R12 set wins wr1", d, 8'h08);
        wr(5'h04, 8'h08);
        wr(5'h05, 8'h06);
    endtask

    task automatic t_fast_ch;
        logic [7:0] d;
        wr(5'h02, 8'h04);
        pulse(8'hFF, 1'b0, 1'b0);
        rd(5'h12, d);
        peek(5'h04, d); check("R7 ic read clears", d, 8'hFD);
        wr(5'h14, 8'h77);
        peek(5'h04, d); check("R7 ic write keeps", d, 8'hFD);
        rd(5'h1B, d);
        peek(5'h04, d); check("R8 oc read keeps", d, 8'hFD);
        wr(5'h1B, 8'h12);
        peek(5'h04, d); check("R8 oc write clears", d, 8'hDD);
        wr(5'h04, 8'hFF);
        peek(5'h04, d); check("R11 fast flag write", d, 8'hDD);
        wr(5'h02, 8'h00);
        wr(5'h04, 8'hFF);
    endtask

    task automatic t_fast_misc;
        logic [7:0] d;
        load_cnt(16'hFFFF); run_ctrl(8'h01, 0);
        wr(5'h02, 8'h04);
        rd(5'h01, d);
        peek(5'h05, d); check("R9 cnt read clears", d, 8'h00);
        wr(5'h02, 8'h00);
        load_cnt(16'hFFFF); run_ctrl(8'h01, 0);
        wr(5'h02, 8'h04);
        wr(5'h00, 8'h12);
        peek(5'h05, d); check("R9 cnt write clears", d, 8'h00);
        pulse(8'h00, 1'b1, 1'b1);
        rd(5'h07, d);
        peek(5'h05, d); check("R10 pa read clears", d, 8'h00);
        pulse(8'h00, 1'b1, 1'b1);
        wr(5'h06, 8'h3C);
        peek(5'h05, d); check("R10 pa write clears", d, 8'h00);
        pulse(8'h00, 1'b1, 1'b0);
        pa_edge_evt = 1'b1;
        rd(5'h06, d);
        pa_edge_evt = 1'b0;
        peek(5'h05, d); check("R12 set wins fast", d, 8'h04);
        wr(5'h02, 8'h00);
    endtask

    initial begin
        #5000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_freeze();
        t_wrap();
        t_normal();
        t_fast_ch();
        t_fast_misc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule